// File: doc/BRIEF.md
# Register Rename Table with Zero-Flag Renaming

This block performs the renaming step of a single-stage decode, rename and dispatch pipeline. It maps 16 architectural registers onto a pool of 32 physical registers. It also renames the single zero condition flag. The flag is not given registers of its own. A flag-producing instruction keeps its zero/non-zero result in a 1-bit extension of the physical register that receives its data result. One extra entry in the mapping table records which physical register holds the newest flag.

Each cycle the block can accept one instruction. The instruction brings two source register numbers, a destination number, a destination-write indication and a flag-write indication. In the same cycle the block returns the following:
- the physical tags of both sources;
- the tag currently holding the flag;
- a newly allocated destination tag;
- the previous mappings of the destination and of the flag, which the reorder logic keeps until commit;
- ready status for each source and for the flag, and the stored zero value.

A writeback port marks a physical register as holding a value and records its zero bit. A commit-time release port hands back the previous data mapping and the previous flag mapping of a retiring instruction. A physical register goes back to the pool only when nothing refers to it any more: no data mapping and no flag mapping.

Top module: `flag_rename_unit`

## Requirements
- R1: After reset, architectural register r maps to physical register r. All physical registers read as holding a value, with zero extension 0. The flag entry names physical register 0. Physical registers 16 to 31 are free and ren_ready is 1.
- R2: When ren_valid, ren_ready and ren_dst_we are all 1, ren_ptag_dst is the lowest-numbered free physical register and ren_ptag_prev is the destination's current mapping. From the next cycle the destination maps to ren_ptag_dst.
- R3: Source and flag lookups made in the same cycle as a rename return the mappings as they stood before that rename's update, including when a source equals the destination.
- R4: An allocated register leaves the free pool. ren_ready is 0 exactly when no physical register is free. While ren_ready is 0, an offered rename changes no mapping.
- R5: When a rename has ren_flag_we and ren_dst_we both set, the flag entry points to the new destination from the next cycle, and ren_ptag_prev_flag gives the old flag entry. ren_flag_we without ren_dst_we has no effect.
- R6: rel_valid drops the data reference of rel_tag, and rel_flag_valid drops the flag reference of rel_flag_tag. A register becomes free only when it has neither reference. The free pool state is observable as ren_ptag_dst, the lowest-numbered free register.
- R7: A writeback (wb_valid) marks wb_tag as holding a value and stores wb_zero in its extension. ren_zero_flag reports the extension of the register named by the flag entry.
- R8: Allocation marks the new destination as not holding a value. A writeback in the same cycle as a lookup is reflected at once in ren_rdy_a, ren_rdy_b, ren_rdy_flag and ren_zero_flag.
- R9: With ren_valid at 0, no mapping changes and no register is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is offered for renaming |
| ren_src_a | input | 4 | First source architectural register |
| ren_src_b | input | 4 | Second source architectural register |
| ren_dst | input | 4 | Destination architectural register |
| ren_dst_we | input | 1 | Instruction writes ren_dst |
| ren_flag_we | input | 1 | Instruction also produces the zero flag |
| ren_ready | output | 1 | A physical register is free; rename can proceed |
| ren_ptag_a | output | 5 | Physical tag of ren_src_a |
| ren_ptag_b | output | 5 | Physical tag of ren_src_b |
| ren_ptag_flag | output | 5 | Physical register holding the newest zero flag |
| ren_ptag_dst | output | 5 | Newly allocated destination tag (lowest free) |
| ren_ptag_prev | output | 5 | Previous mapping of ren_dst |
| ren_ptag_prev_flag | output | 5 | Previous flag entry |
| ren_rdy_a | output | 1 | ren_ptag_a holds a value |
| ren_rdy_b | output | 1 | ren_ptag_b holds a value |
| ren_rdy_flag | output | 1 | Flag register holds a value |
| ren_zero_flag | output | 1 | Zero extension of the flag register |
| wb_valid | input | 1 | Writeback of a physical register |
| wb_tag | input | 5 | Register written back |
| wb_zero | input | 1 | Zero result of the writeback |
| rel_valid | input | 1 | Release the data reference of rel_tag |
| rel_tag | input | 5 | Previous data mapping of a committed instruction |
| rel_flag_valid | input | 1 | Release the flag reference of rel_flag_tag |
| rel_flag_tag | input | 5 | Previous flag mapping of a committed instruction |

## Verification
Several behaviours are checked by assertions on every cycle:
- mapping-table updates for data and flag entries;
- the removal of an allocated register from the pool;
- a register still named by the flag entry staying out of the pool after its data release;
- the valid and zero-bit updates caused by allocation and writeback.

Other behaviours can only be shown by the bench's scenarios, because they depend on whole sequences:
- pre-update lookups when a source equals the destination;
- lowest-first allocation order after out-of-order releases;
- stalling once the pool is drained;
- ignored flag writes;
- same-cycle writeback forwarding into the ready bits.

// File: rtl/frn_pkg.sv
package frn_pkg;
  // Index of the lowest set bit, 0 when none is set.
  function automatic int pick_lowest(input logic [63:0] vec);
    pick_lowest = 0;
    for (int i = 63; i >= 0; i--) begin
      if (vec[i]) pick_lowest = i;
    end
  endfunction
endpackage

// File: rtl/frn_map_table.sv
module frn_map_table #(
  parameter int ARCH_N = 16,
  parameter int PHYS_N = 32,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] wr_arch,
  input  logic          wr_en,
  input  logic          wr_flag_en,
  input  logic [PW-1:0] wr_phys,
  output logic [PW-1:0] tag_a,
  output logic [PW-1:0] tag_b,
  output logic [PW-1:0] tag_flag,
  output logic [PW-1:0] tag_prev
);
  logic [PW-1:0] map_q [ARCH_N];
  logic [PW-1:0] flag_q;

  // Reads see the state before this cycle's write.
  assign tag_a    = map_q[rd_a];
  assign tag_b    = map_q[rd_b];
  assign tag_prev = map_q[wr_arch];
  assign tag_flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= PW'(i);
      flag_q <= '0;
    end else begin
      if (wr_en) map_q[wr_arch] <= wr_phys;
      if (wr_en && wr_flag_en) flag_q <= wr_phys;
    end
  end

  assert_map_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_arch)] == $past(wr_phys));

  assert_flag_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_flag_en) |=> flag_q == $past(wr_phys));
endmodule

// File: rtl/frn_free_pool.sv
module frn_free_pool
  import frn_pkg::*;
#(
  parameter int ARCH_N = 16,
  parameter int PHYS_N = 32,
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          alloc_flag,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_tag,
  input  logic          rel_flag_en,
  input  logic [PW-1:0] rel_flag_tag,
  output logic          any_free,
  output logic [PW-1:0] alloc_tag
);
  logic [PHYS_N-1:0] data_ref_q, flag_ref_q;
  logic [PHYS_N-1:0] data_ref_d, flag_ref_d;
  logic [PHYS_N-1:0] free_vec;

  assign free_vec  = ~(data_ref_q | flag_ref_q);
  assign any_free  = |free_vec;
  assign alloc_tag = PW'(pick_lowest(64'(free_vec)));

  always_comb begin
    data_ref_d = data_ref_q;
    flag_ref_d = flag_ref_q;
    if (rel_en)      data_ref_d[rel_tag]      = 1'b0;
    if (rel_flag_en) flag_ref_d[rel_flag_tag] = 1'b0;
    if (alloc_en) begin
      data_ref_d[alloc_tag] = 1'b1;
      if (alloc_flag) flag_ref_d[alloc_tag] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++) data_ref_q[i] <= (i < ARCH_N);
      flag_ref_q <= PHYS_N'(1);
    end else begin
      data_ref_q <= data_ref_d;
      flag_ref_q <= flag_ref_d;
    end
  end

  assert_alloc_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !free_vec[$past(alloc_tag)]);

  assert_flag_ref_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && flag_ref_q[rel_tag] && !(rel_flag_en && rel_flag_tag == rel_tag))
    |=> !free_vec[$past(rel_tag)]);

  assert_last_ref_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && data_ref_q[rel_tag] && !flag_ref_q[rel_tag])
    |=> free_vec[$past(rel_tag)]);
endmodule

// File: rtl/frn_status.sv
module frn_status #(
  parameter int PHYS_N = 32,
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [PW-1:0] alloc_tag,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_tag,
  input  logic          wb_zero,
  input  logic [PW-1:0] look_a,
  input  logic [PW-1:0] look_b,
  input  logic [PW-1:0] look_f,
  output logic          rdy_a,
  output logic          rdy_b,
  output logic          rdy_f,
  output logic          zero_f
);
  logic [PHYS_N-1:0] valid_q;
  logic [PHYS_N-1:0] zext_q;
  logic              wb_hit_f;

  function automatic logic is_ready(input logic [PHYS_N-1:0] vld, input logic [PW-1:0] t,
                                    input logic wv, input logic [PW-1:0] wt);
    return vld[t] | (wv && wt == t);
  endfunction

  assign rdy_a    = is_ready(valid_q, look_a, wb_valid, wb_tag);
  assign rdy_b    = is_ready(valid_q, look_b, wb_valid, wb_tag);
  assign rdy_f    = is_ready(valid_q, look_f, wb_valid, wb_tag);
  assign wb_hit_f = wb_valid && wb_tag == look_f;
  assign zero_f   = wb_hit_f ? wb_zero : zext_q[look_f];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '1;
      zext_q  <= '0;
    end else begin
      if (alloc_en) valid_q[alloc_tag] <= 1'b0;
      if (wb_valid) begin
        valid_q[wb_tag] <= 1'b1;
        zext_q[wb_tag]  <= wb_zero;
      end
    end
  end

  assert_wb_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (valid_q[$past(wb_tag)] && zext_q[$past(wb_tag)] == $past(wb_zero)));

  assert_alloc_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !(wb_valid && wb_tag == alloc_tag)) |=> !valid_q[$past(alloc_tag)]);
endmodule

// File: rtl/flag_rename_unit.sv
module flag_rename_unit #(
  parameter int ARCH_N = 16,
  parameter int PHYS_N = 32,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  input  logic          ren_dst_we,
  input  logic          ren_flag_we,
  output logic          ren_ready,
  output logic [PW-1:0] ren_ptag_a,
  output logic [PW-1:0] ren_ptag_b,
  output logic [PW-1:0] ren_ptag_flag,
  output logic [PW-1:0] ren_ptag_dst,
  output logic [PW-1:0] ren_ptag_prev,
  output logic [PW-1:0] ren_ptag_prev_flag,
  output logic          ren_rdy_a,
  output logic          ren_rdy_b,
  output logic          ren_rdy_flag,
  output logic          ren_zero_flag,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_tag,
  input  logic          wb_zero,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  input  logic          rel_flag_valid,
  input  logic [PW-1:0] rel_flag_tag
);
  logic          alloc_fire;
  logic          flag_fire;
  logic          pool_has_free;
  logic [PW-1:0] new_tag;

  assign ren_ready          = pool_has_free;
  assign alloc_fire         = ren_valid && pool_has_free && ren_dst_we;
  assign flag_fire          = alloc_fire && ren_flag_we;
  assign ren_ptag_dst       = new_tag;
  assign ren_ptag_prev_flag = ren_ptag_flag;

  frn_map_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(ren_src_a), .rd_b(ren_src_b), .wr_arch(ren_dst),
    .wr_en(alloc_fire), .wr_flag_en(flag_fire), .wr_phys(new_tag),
    .tag_a(ren_ptag_a), .tag_b(ren_ptag_b), .tag_flag(ren_ptag_flag),
    .tag_prev(ren_ptag_prev)
  );

  frn_free_pool #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire), .alloc_flag(flag_fire),
    .rel_en(rel_valid), .rel_tag(rel_tag),
    .rel_flag_en(rel_flag_valid), .rel_flag_tag(rel_flag_tag),
    .any_free(pool_has_free), .alloc_tag(new_tag)
  );

  frn_status #(.PHYS_N(PHYS_N)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire), .alloc_tag(new_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_zero(wb_zero),
    .look_a(ren_ptag_a), .look_b(ren_ptag_b), .look_f(ren_ptag_flag),
    .rdy_a(ren_rdy_a), .rdy_b(ren_rdy_b), .rdy_f(ren_rdy_flag),
    .zero_f(ren_zero_flag)
  );
endmodule

// File: tb/sim_flag_rename_unit.sv
`timescale 1ns/1ps
module sim_flag_rename_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_dst_we = 1'b0, ren_flag_we = 1'b0;
  logic [3:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
  logic ren_ready, ren_rdy_a, ren_rdy_b, ren_rdy_flag, ren_zero_flag;
  logic [4:0] ren_ptag_a, ren_ptag_b, ren_ptag_flag, ren_ptag_dst, ren_ptag_prev, ren_ptag_prev_flag;
  logic wb_valid = 1'b0, wb_zero = 1'b0, rel_valid = 1'b0, rel_flag_valid = 1'b0;
  logic [4:0] wb_tag = '0, rel_tag = '0, rel_flag_tag = '0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  flag_rename_unit u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
    .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_dst_we(ren_dst_we),
    .ren_flag_we(ren_flag_we), .ren_ready(ren_ready), .ren_ptag_a(ren_ptag_a),
    .ren_ptag_b(ren_ptag_b), .ren_ptag_flag(ren_ptag_flag), .ren_ptag_dst(ren_ptag_dst),
    .ren_ptag_prev(ren_ptag_prev), .ren_ptag_prev_flag(ren_ptag_prev_flag),
    .ren_rdy_a(ren_rdy_a), .ren_rdy_b(ren_rdy_b), .ren_rdy_flag(ren_rdy_flag),
    .ren_zero_flag(ren_zero_flag), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_zero(wb_zero),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_flag_valid(rel_flag_valid),
    .rel_flag_tag(rel_flag_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int a, input int b);
    ren_valid = 0; ren_dst_we = 0; ren_flag_we = 0; ren_dst = 0;
    ren_src_a = 4'(a); ren_src_b = 4'(b);
    wb_valid = 0; rel_valid = 0; rel_flag_valid = 0;
  endtask

  task automatic offer(input int a, input int b, input int d, input logic dwe, input logic fwe);
    idle(a, b);
    ren_valid = 1; ren_dst = 4'(d); ren_dst_we = dwe; ren_flag_we = fwe;
  endtask

  task automatic t_reset();
    idle(3, 15); #1;
    check("R1 ptag_a", ren_ptag_a, 3);
    check("R1 ptag_b", ren_ptag_b, 15);
    check("R1 flag entry", ren_ptag_flag, 0);
    check("R1 ready", ren_ready, 1);
    check("R1 rdy_a", ren_rdy_a, 1);
    check("R1 zero ext", ren_zero_flag, 0);
    check("R1 first free", ren_ptag_dst, 16);
  endtask

  task automatic t_basic();
    offer(1, 2, 3, 1, 0); #1;
    check("R2 dst tag", ren_ptag_dst, 16);
    check("R2 prev", ren_ptag_prev, 3);
    check("R2 src a", ren_ptag_a, 1);
    tick(); idle(3, 0); #1;
    check("R2 map updated", ren_ptag_a, 16);
    check("R8 alloc not ready", ren_rdy_a, 0);
    check("R5 flag unchanged", ren_ptag_flag, 0);
  endtask

  task automatic t_same_cycle();
    offer(5, 3, 5, 1, 1); #1;
    check("R3 src equals dst", ren_ptag_a, 5);
    check("R3 other src", ren_ptag_b, 16);
    check("R3 flag pre-update", ren_ptag_flag, 0);
    check("R2 dst tag 17", ren_ptag_dst, 17);
    check("R5 prev flag", ren_ptag_prev_flag, 0);
    tick(); idle(5, 0); #1;
    check("R2 r5 mapped", ren_ptag_a, 17);
    check("R5 flag moved", ren_ptag_flag, 17);
    check("R8 flag not ready", ren_rdy_flag, 0);
  endtask

  task automatic t_ignored();
    idle(0, 0); ren_dst = 9; ren_dst_we = 1; ren_flag_we = 1;
    tick();
    offer(0, 0, 9, 0, 1);
    tick(); idle(9, 0); #1;
    check("R9 no map change", ren_ptag_a, 9);
    check("R5 flag-only ignored", ren_ptag_flag, 17);
    check("R9 no allocation", ren_ptag_dst, 18);
  endtask

  task automatic t_writeback();
    idle(5, 3); wb_valid = 1; wb_tag = 17; wb_zero = 1; #1;
    check("R8 bypass rdy_a", ren_rdy_a, 1);
    check("R8 no bypass rdy_b", ren_rdy_b, 0);
    check("R8 bypass flag rdy", ren_rdy_flag, 1);
    check("R8 bypass zero", ren_zero_flag, 1);
    tick(); idle(5, 0); #1;
    check("R7 stored ready", ren_rdy_a, 1);
    check("R7 stored zero", ren_zero_flag, 1);
  endtask

  task automatic t_release();
    offer(5, 5, 5, 1, 0); #1;
    check("R2 dst 18", ren_ptag_dst, 18);
    check("R2 prev 17", ren_ptag_prev, 17);
    tick(); idle(0, 0); rel_valid = 1; rel_tag = 17;
    tick(); idle(0, 0); #1;
    check("R6 flag ref keeps 17", ren_ptag_dst, 19);
    rel_valid = 1; rel_tag = 3;
    tick(); idle(0, 0); #1;
    check("R6 freed 3", ren_ptag_dst, 3);
    offer(0, 0, 6, 1, 1); #1;
    check("R6 alloc 3", ren_ptag_dst, 3);
    check("R5 prev flag 17", ren_ptag_prev_flag, 17);
    tick(); idle(0, 0); rel_flag_valid = 1; rel_flag_tag = 17;
    tick(); idle(0, 0); #1;
    check("R6 last ref frees 17", ren_ptag_dst, 17);
  endtask

  task automatic t_exhaust();
    for (int k = 0; k < 14; k++) begin
      offer(0, 0, 7, 1, 0); #1;
      check("R4 alloc order", ren_ptag_dst, (k == 0) ? 17 : 18 + k);
      tick();
    end
    idle(0, 0); #1;
    check("R4 ready low", ren_ready, 0);
    offer(0, 0, 8, 1, 0);
    tick(); idle(8, 0); #1;
    check("R4 stalled no map", ren_ptag_a, 8);
    rel_valid = 1; rel_tag = 6;
    tick(); idle(0, 0); #1;
    check("R4 ready again", ren_ready, 1);
    check("R6 freed 6", ren_ptag_dst, 6);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    tick();
    t_basic();
    tick();
    t_same_cycle();
    tick();
    t_ignored();
    t_writeback();
    tick();
    t_release();
    t_exhaust();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule